// File: doc/BRIEF.md
# Supply and Battery Health Sequencer

This block times the housekeeping of a battery-backed memory module. It watches two digital flags from external comparators: `supply_ok`, high while the main supply is inside its tolerance band, and `batt_low`, high while the backup cell reads below its trip level. From these it drives four outputs:

- an active-low processor reset that is held for a programmable interval after the supply becomes good;
- a load-enable that places the cell under a test load for a fixed window;
- a warning flag that latches the result of the cell test;
- a seal enable that connects the backup cell the first time the supply is seen good.

All time is counted in pulses of a prescaled `tick` input, one clock wide. Every duration is a parameter, so a bench can shrink hours to a handful of ticks. `supply_ok`, `batt_low` and `tick` are taken to be synchronous to `clk`.

Two state machines do the work. The reset controller has three states. RS_DOWN goes to RS_HOLD when the supply is good. RS_HOLD goes to RS_RUN after HOLD_TICKS ticks. Both RS_HOLD and RS_RUN drop back to RS_DOWN as soon as the supply fails.

The battery tester has five states. BT_OFF goes to BT_RECOV on supply good. BT_RECOV goes to BT_LOAD after REC_TICKS ticks. BT_LOAD lasts PULSE_TICKS ticks and then goes to BT_WAIT if the cell passed, or to BT_HALT if it failed. BT_WAIT goes back to BT_LOAD after PERIOD_TICKS ticks. BT_HALT stays where it is. Every state returns to BT_OFF when the supply fails. The seal is a single flag that is set by a good supply and cleared only by the dedicated `seal_clr_n` input.

Top module: `supply_health_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with `supply_ok` low, `cpu_rst_n`, `load_en` and `batt_warn` are 0.
- R2: When `supply_ok` is sampled low at a clock edge, `cpu_rst_n` is 0 after that edge.
- R3: After `supply_ok` goes high, `cpu_rst_n` stays 0 until the edge that samples the HOLD_TICKS-th tick, and is 1 after that edge.
- R4: At every power-up, `load_en` rises at the edge that samples the REC_TICKS-th tick after `supply_ok` goes high. It stays 1 for exactly PULSE_TICKS ticks.
- R5: After a passing test releases the load, the next test starts at the edge that samples the PERIOD_TICKS-th following tick.
- R6: If `batt_low` is 1 at any edge while `load_en` is 1, `batt_warn` becomes 1 when the load is released. It then stays 1, and no periodic test runs until the supply has failed and returned.
- R7: A test runs at every power-up even when `batt_warn` is 1. A passing result clears `batt_warn` to 0 and restarts the periodic schedule.
- R8: If the supply fails during a test, `load_en` is 0 after the next edge and `batt_warn` keeps its previous value. No test runs while `supply_ok` is low.
- R9: `seal_en` is 0 from `seal_clr_n` low until `supply_ok` is first sampled high, and 1 from then on. It is unaffected by `rst_n` and by supply loss, and is cleared only by `seal_clr_n`.
- R10: `batt_low` has no effect while `load_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencers and the warning latch |
| seal_clr_n | input | 1 | Asynchronous active-low test reset that re-arms the seal |
| tick | input | 1 | One-cycle time base pulse |
| supply_ok | input | 1 | Supply-in-tolerance comparator flag |
| batt_low | input | 1 | Cell-below-threshold comparator flag |
| cpu_rst_n | output | 1 | Active-low processor reset |
| load_en | output | 1 | Test load enable |
| batt_warn | output | 1 | Latched battery warning |
| seal_en | output | 1 | Backup cell connect enable |

## Verification
The supply drop takes effect at the first edge that samples it. Reset release, test start and test end each land on the edge that samples the deciding tick. The warning changes at the same edge that ends the load. The bench drives every input at a falling edge, with each tick lasting exactly one cycle, and samples the outputs at the next falling edge. Each check therefore sees the result of exactly one rising edge.

Windows that must stay quiet, such as no test during a halt, no test while the supply is down, or a `batt_low` that must be ignored, are covered by watching `load_en` at every falling edge across the whole window.

// File: rtl/shs_pkg.sv
package shs_pkg;

    typedef enum logic [1:0] {
        RS_DOWN,
        RS_HOLD,
        RS_RUN
    } rst_state_t;

    typedef enum logic [2:0] {
        BT_OFF,
        BT_RECOV,
        BT_LOAD,
        BT_WAIT,
        BT_HALT
    } bt_state_t;

endpackage

// File: rtl/shs_tick_cnt.sv
// Tick interval counter: done pulses with the limit-th tick since clear.
module shs_tick_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    assign done = en && tick && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/shs_rst_ctrl.sv
// Processor reset sequencer: immediate assert, timed release.
module shs_rst_ctrl
    import shs_pkg::*;
#(
    parameter int CW         = 8,
    parameter int HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    output logic cpu_rst_n
);
    localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_TICKS);

    rst_state_t state_q, state_d;
    logic       hold_done;

    shs_tick_cnt #(.CW(CW)) u_hold_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != RS_HOLD),
        .en    (state_q == RS_HOLD),
        .tick  (tick),
        .limit (HOLD_LIM),
        .done  (hold_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_DOWN: if (supply_ok) state_d = RS_HOLD;
            RS_HOLD: begin
                if (!supply_ok)     state_d = RS_DOWN;
                else if (hold_done) state_d = RS_RUN;
            end
            RS_RUN:  if (!supply_ok) state_d = RS_DOWN;
            default: state_d = RS_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        cpu_rst_n = (state_q == RS_RUN);
    end
endmodule

// File: rtl/shs_batt_fsm.sv
// Battery test scheduler and warning latch.
module shs_batt_fsm
    import shs_pkg::*;
#(
    parameter int CW           = 8,
    parameter int REC_TICKS    = 150,
    parameter int PERIOD_TICKS = 1000,
    parameter int PULSE_TICKS  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic batt_low,
    output logic load_en,
    output logic batt_warn
);
    localparam logic [CW-1:0] REC_LIM    = CW'(REC_TICKS);
    localparam logic [CW-1:0] PERIOD_LIM = CW'(PERIOD_TICKS);
    localparam logic [CW-1:0] PULSE_LIM  = CW'(PULSE_TICKS);

    bt_state_t     state_q, state_d;
    logic [CW-1:0] limit;
    logic          timed;
    logic          iv_done;
    logic          fail_q;
    logic          fail_now;
    logic          warn_q;

    always_comb begin
        unique case (state_q)
            BT_RECOV: limit = REC_LIM;
            BT_LOAD:  limit = PULSE_LIM;
            default:  limit = PERIOD_LIM;
        endcase
        timed = (state_q == BT_RECOV) || (state_q == BT_LOAD) || (state_q == BT_WAIT);
    end

    shs_tick_cnt #(.CW(CW)) u_iv_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .en    (timed),
        .tick  (tick),
        .limit (limit),
        .done  (iv_done)
    );

    // result of the current test including the sample at this edge
    assign fail_now = fail_q || batt_low;

    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = BT_OFF;
        end else begin
            unique case (state_q)
                BT_OFF:   state_d = BT_RECOV;
                BT_RECOV: if (iv_done) state_d = BT_LOAD;
                BT_LOAD:  if (iv_done) state_d = fail_now ? BT_HALT : BT_WAIT;
                BT_WAIT:  if (iv_done) state_d = BT_LOAD;
                BT_HALT:  state_d = BT_HALT;
                default:  state_d = BT_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BT_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            warn_q <= 1'b0;
        end else begin
            if (state_q != BT_LOAD)  fail_q <= 1'b0;
            else if (batt_low)       fail_q <= 1'b1;
            if (state_q == BT_LOAD && supply_ok && iv_done) warn_q <= fail_now;
        end
    end

    always_comb begin
        load_en   = (state_q == BT_LOAD);
        batt_warn = warn_q;
    end
endmodule

// File: rtl/shs_seal.sv
// Backup cell connect flag: set by a good supply, cleared only by the test reset.
module shs_seal (
    input  logic clk,
    input  logic seal_clr_n,
    input  logic supply_ok,
    output logic seal_en
);
    always_ff @(posedge clk or negedge seal_clr_n) begin
        if (!seal_clr_n)    seal_en <= 1'b0;
        else if (supply_ok) seal_en <= 1'b1;
    end
endmodule

// File: rtl/supply_health_seq.sv
module supply_health_seq #(
    parameter int HOLD_TICKS   = 200,
    parameter int REC_TICKS    = 150,
    parameter int PERIOD_TICKS = 86400000,
    parameter int PULSE_TICKS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seal_clr_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic batt_low,
    output logic cpu_rst_n,
    output logic load_en,
    output logic batt_warn,
    output logic seal_en
);
    localparam int MAX_A  = (HOLD_TICKS > REC_TICKS) ? HOLD_TICKS : REC_TICKS;
    localparam int MAX_B  = (PERIOD_TICKS > PULSE_TICKS) ? PERIOD_TICKS : PULSE_TICKS;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_T + 1);

    shs_rst_ctrl #(
        .CW         (CW),
        .HOLD_TICKS (HOLD_TICKS)
    ) u_rst_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .supply_ok (supply_ok),
        .cpu_rst_n (cpu_rst_n)
    );

    shs_batt_fsm #(
        .CW           (CW),
        .REC_TICKS    (REC_TICKS),
        .PERIOD_TICKS (PERIOD_TICKS),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_batt_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .supply_ok (supply_ok),
        .batt_low  (batt_low),
        .load_en   (load_en),
        .batt_warn (batt_warn)
    );

    shs_seal u_seal (
        .clk        (clk),
        .seal_clr_n (seal_clr_n),
        .supply_ok  (supply_ok),
        .seal_en    (seal_en)
    );
endmodule

// File: rtl/shs_checker.sv
module shs_checker (
    input logic clk,
    input logic rst_n,
    input logic seal_clr_n,
    input logic supply_ok,
    input logic cpu_rst_n,
    input logic load_en,
    input logic batt_warn,
    input logic seal_en
);
    assert_rst_on_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !cpu_rst_n);

    assert_release_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> $past(supply_ok));

    assert_load_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !load_en);

    assert_warn_at_test_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(batt_warn) |-> $fell(load_en));

    assert_seal_sticky_R9: assert property (@(posedge clk) disable iff (!seal_clr_n)
        seal_en |=> seal_en);

    assert_seal_on_supply_R9: assert property (@(posedge clk) disable iff (!seal_clr_n)
        supply_ok |=> seal_en);
endmodule

bind supply_health_seq shs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seal_clr_n (seal_clr_n),
    .supply_ok  (supply_ok),
    .cpu_rst_n  (cpu_rst_n),
    .load_en    (load_en),
    .batt_warn  (batt_warn),
    .seal_en    (seal_en)
);

// File: tb/supply_health_seq_tb.sv
module supply_health_seq_tb;
    localparam int HOLD   = 5;
    localparam int REC    = 2;
    localparam int PERIOD = 6;
    localparam int PULSE  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seal_clr_n = 1'b0;
    logic tick = 1'b0;
    logic supply_ok = 1'b0;
    logic batt_low = 1'b0;
    logic cpu_rst_n, load_en, batt_warn, seal_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic seen_load;

    always #4 clk = ~clk;

    supply_health_seq #(
        .HOLD_TICKS   (HOLD),
        .REC_TICKS    (REC),
        .PERIOD_TICKS (PERIOD),
        .PULSE_TICKS  (PULSE)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .seal_clr_n (seal_clr_n),
        .tick       (tick),
        .supply_ok  (supply_ok),
        .batt_low   (batt_low),
        .cpu_rst_n  (cpu_rst_n),
        .load_en    (load_en),
        .batt_warn  (batt_warn),
        .seal_en    (seal_en)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen_load = seen_load | load_en;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen_load = seen_load | load_en;
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            seen_load = seen_load | load_en;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; seal_clr_n = 1'b0; supply_ok = 1'b0;
        idle(2);
        check("R1 cpu_rst_n in reset", cpu_rst_n, 1'b0);
        check("R1 load_en in reset", load_en, 1'b0);
        check("R1 batt_warn in reset", batt_warn, 1'b0);
        rst_n = 1'b1; seal_clr_n = 1'b1;
        idle(2);
        check("R1 cpu_rst_n after reset", cpu_rst_n, 1'b0);
        check("R9 seal_en before first supply", seal_en, 1'b0);
    endtask

    task automatic t_first_powerup;
        supply_ok = 1'b1;
        idle(1);
        check("R9 seal_en after supply good", seal_en, 1'b1);
        check("R3 cpu_rst_n held", cpu_rst_n, 1'b0);
        ticks(REC - 1);
        check("R4 load_en before recovery end", load_en, 1'b0);
        ticks(1);
        check("R4 load_en at recovery end", load_en, 1'b1);
        ticks(HOLD - REC - 1);
        check("R3 cpu_rst_n one tick before hold end", cpu_rst_n, 1'b0);
        check("R4 load_en during pulse", load_en, 1'b1);
        ticks(1);
        check("R3 cpu_rst_n after hold", cpu_rst_n, 1'b1);
        check("R4 load_en after pulse", load_en, 1'b0);
        check("R4 batt_warn after pass", batt_warn, 1'b0);
    endtask

    task automatic t_ignore_and_period;
        batt_low = 1'b1;
        seen_load = 1'b0;
        ticks(PERIOD - 1);
        check("R10 no load between tests", seen_load, 1'b0);
        check("R10 batt_low ignored outside test", batt_warn, 1'b0);
        batt_low = 1'b0;
        ticks(1);
        check("R5 periodic test starts", load_en, 1'b1);
        ticks(PULSE);
        check("R5 periodic test ends", load_en, 1'b0);
        check("R5 pass keeps warn clear", batt_warn, 1'b0);
    endtask

    task automatic t_fail_latch;
        ticks(PERIOD);
        check("R5 second periodic test", load_en, 1'b1);
        batt_low = 1'b1;
        idle(1);
        batt_low = 1'b0;
        ticks(PULSE);
        check("R6 load released", load_en, 1'b0);
        check("R6 warn latched", batt_warn, 1'b1);
        seen_load = 1'b0;
        ticks(4 * PERIOD);
        check("R6 periodic tests halted", seen_load, 1'b0);
        check("R6 warn stays", batt_warn, 1'b1);
    endtask

    task automatic t_supply_drop;
        supply_ok = 1'b0;
        idle(1);
        check("R2 cpu_rst_n on supply loss", cpu_rst_n, 1'b0);
        check("R8 warn kept over supply loss", batt_warn, 1'b1);
        seen_load = 1'b0;
        ticks(2 * PERIOD);
        check("R8 no test while supply low", seen_load, 1'b0);
        check("R9 seal stays over supply loss", seal_en, 1'b1);
    endtask

    task automatic t_powerup_clear;
        supply_ok = 1'b1;
        idle(1);
        ticks(REC);
        check("R7 power-up test runs with warn set", load_en, 1'b1);
        check("R7 warn still set during test", batt_warn, 1'b1);
        ticks(PULSE);
        check("R7 pass clears warn", batt_warn, 1'b0);
        check("R3 cpu_rst_n released", cpu_rst_n, 1'b1);
        ticks(PERIOD);
        check("R7 schedule restarted", load_en, 1'b1);
    endtask

    task automatic t_abort;
        batt_low = 1'b1;
        ticks(1);
        supply_ok = 1'b0;
        idle(1);
        check("R8 load dropped on abort", load_en, 1'b0);
        check("R8 warn unchanged on abort", batt_warn, 1'b0);
        check("R2 cpu_rst_n on abort", cpu_rst_n, 1'b0);
        supply_ok = 1'b1;
        idle(1);
        ticks(REC + PULSE);
        check("R6 failing power-up test sets warn", batt_warn, 1'b1);
        check("R6 load released after failing test", load_en, 1'b0);
        batt_low = 1'b0;
    endtask

    task automatic t_seal;
        supply_ok = 1'b0;
        idle(1);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(1);
        check("R9 seal unaffected by rst_n", seal_en, 1'b1);
        check("R1 warn cleared by rst_n", batt_warn, 1'b0);
        seal_clr_n = 1'b0;
        idle(1);
        check("R9 seal cleared by test reset", seal_en, 1'b0);
        seal_clr_n = 1'b1;
        idle(2);
        check("R9 seal stays clear without supply", seal_en, 1'b0);
        supply_ok = 1'b1;
        idle(1);
        check("R9 seal set again on supply", seal_en, 1'b1);
    endtask

    initial begin
        seen_load = 1'b0;
        t_reset();
        t_first_powerup();
        t_ignore_and_period();
        t_fail_latch();
        t_supply_drop();
        t_powerup_clear();
        t_abort();
        t_seal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule